// File: doc/BRIEF.md
# Instruction Holding and Read-Byte Assembly Unit

This unit keeps the opcode that the processor is currently executing. A sequencer tells it when to load a new opcode. That opcode normally comes from the 8-bit read bus. An opcode fetched ahead of time can instead be parked in a one-entry prefetch buffer. The next instruction load then takes it from the buffer, so the fetch can overlap a data transfer. When an exception is taken, a fixed trap opcode is forced into the instruction register. The trap overrides every other source and throws away any parked opcode.

The same read bus is also passed on in two 16-bit forms. The first is the incoming byte widened with zeros. The second joins the incoming byte, as the upper half, with a byte captured earlier, as the lower half. This lets a 16-bit operand be built from two successive byte reads.

Top module: `ifu_core`

## Requirements
- R1: A synchronous reset sets the instruction output to the no-operation code (default 0x00), clears the prefetch-valid flag and clears the held low byte to 0.
- R2: When the prefetch strobe is high and no trap is requested, the read byte is stored in the prefetch buffer and the prefetch-valid flag is 1 after the edge.
- R3: When the instruction load strobe is high, the buffer is valid and no trap is requested, the instruction becomes the buffered byte. The valid flag is then 0, unless a prefetch strobe arrives in the same cycle.
- R4: When the instruction load strobe is high, the buffer is empty and no trap is requested, the instruction becomes the read byte.
- R5: A trap request loads the trap code (default 0xA5) into the instruction register and clears the prefetch-valid flag. Any instruction load or prefetch strobe in that cycle is ignored.
- R6: With neither the instruction load strobe nor a trap request, the instruction output keeps its value.
- R7: The zero-extended output always equals {8'h00, read byte} in the same cycle.
- R8: The capture strobe stores the read byte as the held low byte, which is kept otherwise. The assembled output always equals {read byte, held low byte}.
- R9: When an instruction load from a valid buffer and a prefetch strobe fall in the same cycle, the instruction becomes the old buffered byte, the buffer takes the new read byte, and the valid flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_data | input | 8 | Read data bus byte |
| ir_load | input | 1 | Load the instruction register this cycle |
| pf_load | input | 1 | Park the read byte in the prefetch buffer |
| trap_req | input | 1 | Force the trap opcode into the instruction register |
| lo_capture | input | 1 | Capture the read byte as the low byte of a word |
| instr | output | 8 | Current instruction |
| pf_valid | output | 1 | Prefetch buffer holds an unconsumed opcode |
| rd_zext | output | 16 | Read byte zero-extended |
| rd_word | output | 16 | Read byte joined above the held low byte |

## Verification
The delicate overlap is an instruction load that drains the prefetch buffer in the same cycle as a prefetch strobe that refills it. The old byte must move to the instruction register while the new byte takes its place, and the valid flag must stay set. Directed cycles set up this overlap on purpose. Random strobes also produce it, along with trap requests that land on top of it. After each edge a bench reference model checks the instruction and the valid flag. Each new instruction load then shows which byte the buffer really kept.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_BUS  = 2'd1,
        SRC_PF   = 2'd2,
        SRC_TRAP = 2'd3
    } ir_src_e;
endpackage

// File: rtl/ifu_src_sel.sv
module ifu_src_sel
    import ifu_pkg::*;
(
    input  logic    ir_load,
    input  logic    trap_req,
    input  logic    pf_valid,
    output ir_src_e src,
    output logic    pf_take
);
    always_comb begin
        if (trap_req)
            src = SRC_TRAP;
        else if (ir_load && pf_valid)
            src = SRC_PF;
        else if (ir_load)
            src = SRC_BUS;
        else
            src = SRC_HOLD;
        pf_take = (src == SRC_PF);
    end
endmodule

// File: rtl/ifu_prefetch.sv
module ifu_prefetch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] rd_data,
    input  logic          pf_load,
    input  logic          pf_take,
    input  logic          flush,
    output logic [DW-1:0] pf_byte,
    output logic          pf_valid
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
    } pf_state_t;

    pf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.valid = 1'b0;
        end else begin
            if (pf_take)
                st_d.valid = 1'b0;
            if (pf_load) begin
                st_d.data  = rd_data;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pf_byte  = st_q.data;
    assign pf_valid = st_q.valid;

    AST_PF_SET: assert property (@(posedge clk) disable iff (rst)
        (pf_load && !flush) |=> pf_valid);                          // R2
    AST_PF_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (pf_take && !pf_load && !flush) |=> !pf_valid);             // R3
    AST_PF_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush |=> !pf_valid);                                       // R5
    AST_PF_REFILL: assert property (@(posedge clk) disable iff (rst)
        (pf_take && pf_load && !flush) |=> (pf_valid && pf_byte == $past(rd_data))); // R9
endmodule

// File: rtl/ifu_byte_join.sv
module ifu_byte_join #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   rd_data,
    input  logic            lo_capture,
    output logic [2*DW-1:0] rd_zext,
    output logic [2*DW-1:0] rd_word
);
    localparam int WW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] lo;
    } join_state_t;

    join_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_capture)
            st_d.lo = rd_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_zext = {{(WW-DW){1'b0}}, rd_data};
    assign rd_word = {rd_data, st_q.lo};

    AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        lo_capture |=> (st_q.lo == $past(rd_data)));                // R8
    AST_LO_KEEP: assert property (@(posedge clk) disable iff (rst)
        !lo_capture |=> $stable(st_q.lo));                          // R8
endmodule

// File: rtl/ifu_core.sv
module ifu_core
    import ifu_pkg::*;
#(
    parameter int          DW       = 8,
    parameter logic [DW-1:0] NOP_OP = 8'h00,
    parameter logic [DW-1:0] TRAP_OP = 8'hA5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   rd_data,
    input  logic            ir_load,
    input  logic            pf_load,
    input  logic            trap_req,
    input  logic            lo_capture,
    output logic [DW-1:0]   instr,
    output logic            pf_valid,
    output logic [2*DW-1:0] rd_zext,
    output logic [2*DW-1:0] rd_word
);
    typedef struct packed {
        logic [DW-1:0] ir;
    } ir_state_t;

    ir_state_t     st_d, st_q;
    ir_src_e       src;
    logic          pf_take;
    logic [DW-1:0] pf_byte;

    ifu_src_sel u_sel (
        .ir_load  (ir_load),
        .trap_req (trap_req),
        .pf_valid (pf_valid),
        .src      (src),
        .pf_take  (pf_take)
    );

    ifu_prefetch #(.DW(DW)) u_pf (
        .clk      (clk),
        .rst      (rst),
        .rd_data  (rd_data),
        .pf_load  (pf_load),
        .pf_take  (pf_take),
        .flush    (trap_req),
        .pf_byte  (pf_byte),
        .pf_valid (pf_valid)
    );

    ifu_byte_join #(.DW(DW)) u_join (
        .clk        (clk),
        .rst        (rst),
        .rd_data    (rd_data),
        .lo_capture (lo_capture),
        .rd_zext    (rd_zext),
        .rd_word    (rd_word)
    );

    always_comb begin
        st_d = st_q;
        unique case (src)
            SRC_TRAP: st_d.ir = TRAP_OP;
            SRC_PF:   st_d.ir = pf_byte;
            SRC_BUS:  st_d.ir = rd_data;
            default:  st_d.ir = st_q.ir;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{ir: NOP_OP};
        else
            st_q <= st_d;
    end

    assign instr = st_q.ir;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (instr == NOP_OP && !pf_valid));                    // R1
    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (instr == TRAP_OP));                           // R5
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ir_load && !trap_req) |=> $stable(instr));                // R6
    AST_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
        (ir_load && !pf_valid && !trap_req) |=> (instr == $past(rd_data))); // R4
    AST_FROM_PF: assert property (@(posedge clk) disable iff (rst)
        (ir_load && pf_valid && !trap_req) |=> (instr == $past(pf_byte)));  // R3
endmodule

// File: tb/ifu_core_test.sv
module ifu_core_test;
    localparam int PERIOD = 10;
    localparam logic [7:0] NOP  = 8'h00;
    localparam logic [7:0] TRAP = 8'hA5;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  rd_data;
    logic        ir_load, pf_load, trap_req, lo_capture;
    logic [7:0]  instr;
    logic        pf_valid;
    logic [15:0] rd_zext, rd_word;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_ir, m_f, m_h;
    logic       m_v;

    always #(PERIOD/2) clk = ~clk;

    ifu_core uut (
        .clk(clk), .rst(rst), .rd_data(rd_data), .ir_load(ir_load),
        .pf_load(pf_load), .trap_req(trap_req), .lo_capture(lo_capture),
        .instr(instr), .pf_valid(pf_valid), .rd_zext(rd_zext), .rd_word(rd_word)
    );

    function automatic logic [15:0] exp_zext(input logic [7:0] b);
        return {8'h00, b};
    endfunction

    function automatic logic [15:0] exp_word(input logic [7:0] b, input logic [7:0] lo);
        return {b, lo};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model step at a clock edge
    task automatic model_edge;
        if (rst) begin
            m_ir = NOP; m_v = 1'b0; m_h = 8'h00;
        end else begin
            if (lo_capture) m_h = rd_data;
            if (trap_req) begin
                m_ir = TRAP; m_v = 1'b0;
            end else begin
                if (ir_load && m_v) begin
                    m_ir = m_f; m_v = 1'b0;
                end else if (ir_load) begin
                    m_ir = rd_data;
                end
                if (pf_load) begin
                    m_f = rd_data; m_v = 1'b1;
                end
            end
        end
    endtask

    // drive at negedge, check comb outputs, clock, check registered outputs
    task automatic cycle(input logic r, input logic [7:0] d, input logic il,
                         input logic pl, input logic tr, input logic lc, input string tag);
        @(negedge clk);
        rst = r; rd_data = d; ir_load = il; pf_load = pl; trap_req = tr; lo_capture = lc;
        #1;
        if (!r) begin
            check("R7", rd_zext, exp_zext(d));
            check("R8", rd_word, exp_word(d, m_h));
        end
        @(posedge clk);
        model_edge();
        #1;
        check(tag, {8'h00, instr}, {8'h00, m_ir});
        check(tag, {15'h0, pf_valid}, {15'h0, m_v});
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_f = 8'h00;
        rst = 1'b1; rd_data = 8'h00; ir_load = 0; pf_load = 0; trap_req = 0; lo_capture = 0;
        cycle(1, 8'h3C, 1, 1, 0, 1, "R1");
        cycle(1, 8'h00, 0, 0, 0, 0, "R1");
        check("R1", rd_word, 16'h0000);
        // R4: load from bus with empty buffer
        cycle(0, 8'h12, 1, 0, 0, 0, "R4");
        // R6: hold
        cycle(0, 8'h77, 0, 0, 0, 0, "R6");
        // R2: park early fetch
        cycle(0, 8'h34, 0, 1, 0, 0, "R2");
        // R3: consume buffer, bus value ignored
        cycle(0, 8'h99, 1, 0, 0, 0, "R3");
        // R9: drain and refill together
        cycle(0, 8'h56, 0, 1, 0, 0, "R2");
        cycle(0, 8'h78, 1, 1, 0, 0, "R9");
        cycle(0, 8'hEE, 1, 0, 0, 0, "R9");
        // R5: trap over a valid buffer with both strobes
        cycle(0, 8'h41, 0, 1, 0, 0, "R2");
        cycle(0, 8'h42, 1, 1, 1, 0, "R5");
        cycle(0, 8'h43, 1, 0, 0, 0, "R5");
        // R8: capture low byte then join
        cycle(0, 8'hCD, 0, 0, 0, 1, "R8");
        cycle(0, 8'hAB, 0, 0, 0, 0, "R8");
        check("R8", rd_word, 16'hABCD);
        // constrained random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cycle((r[31:26] == 6'd0), r[7:0], r[8] | r[9], r[10] | r[11],
                  (r[14:12] == 3'd0), r[15], "R3");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule